// File: doc/BRIEF.md
# Byte Program Pulse Sequencer

This block is the host side of an in-system programmer for a flash part that is driven through a command register. Software gives it a base address and a byte count and then pulses start. The block fetches each expected byte from a data source and programs it with a closed loop over a parallel bus master port. One attempt has these steps: a setup command write, a write of the data to the target address, a timed program pulse, a verify command write that ends the pulse, a settling wait, and a read-back of the byte. When the byte read back matches, the block moves on to the next address. When it does not match, the same byte gets another pulse. After a fixed number of failed pulses the block gives up.

The programming supply is controlled only through an enable output. That enable goes high when a run starts. It goes low after the final reset command is accepted, or as soon as a byte exhausts its pulse budget. The pulse and settle times are given in microseconds and scaled by a clock-frequency parameter, so a bench can shrink them. A failed run leaves the failing address and its pulse count on outputs until the next start.

Top module: `byte_prog_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, vpp_en_o, bus_req_o and data_req_o are all low.
- R2: A start accepted while idle raises vpp_en_o and busy_o, and clears done_o and fail_o. Each attempt on byte i writes 40h to address base+i and then writes the expected byte to that address. vpp_en_o is high whenever bus_req_o is high.
- R3: The verify write (C0h to the same address) is presented exactly CLK_MHZ*PULSE_US cycles after the edge that accepts the data write.
- R4: The read of the same address is presented exactly CLK_MHZ*SETTLE_US cycles after the edge that accepts the verify write.
- R5: When the byte read back matches, the block moves to the next address. When it differs, the attempt is repeated with the same byte. The pulse count starts from zero for every address, so a byte that needs n pulses (n ≤ MAX_PULSES) gets exactly n attempts.
- R6: If the MAX_PULSES-th read-back of a byte still differs, the run stops with no further bus traffic. vpp_en_o drops, fail_o rises, fail_addr_o holds that address and fail_pulses_o holds MAX_PULSES. These values stay until the next accepted start clears them.
- R7: After the last byte matches, the block writes FFh to the base address. When that write is accepted, vpp_en_o drops, busy_o falls and done_o is held high. A byte count of zero produces only this write.
- R8: A start pulse while busy_o is high is ignored. This includes the edge that accepts the final FFh write. Addresses, sequence and base used stay those latched at the accepted start.
- R9: bus_req_o, bus_we_o (1 = write), bus_addr_o and bus_wdata_o hold steady until bus_ack_i is sampled high. bus_rdata_i is taken on that same edge. An acknowledge in the first cycle of a request is allowed.
- R10: Each byte is fetched once, in order of index 0,1,2,…. data_req_o and data_idx_o are held until data_vld_i is sampled high, and data_i is taken on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run when idle |
| base_addr_i | input | ADDR_W | First target address |
| byte_count_i | input | ADDR_W+1 | Number of bytes to program |
| data_req_o | output | 1 | Request for the next expected byte |
| data_idx_o | output | ADDR_W | Index of the requested byte |
| data_vld_i | input | 1 | Expected byte is on data_i |
| data_i | input | 8 | Expected byte |
| bus_req_o | output | 1 | Bus transaction pending |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 8 | Write data or command |
| bus_ack_i | input | 1 | Transaction completes this edge |
| bus_rdata_i | input | 8 | Read data, valid with bus_ack_i |
| vpp_en_o | output | 1 | Programming supply enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed, held |
| fail_o | output | 1 | Last run aborted on pulse limit, held |
| fail_addr_o | output | ADDR_W | Address that exhausted its pulses |
| fail_pulses_o | output | $clog2(MAX_PULSES+1) | Pulses spent on the failing address |

## Verification
Two events can land on the same clock edge. The first is a fresh start request. The second is the acceptance of the final FFh write, which is the very edge where busy_o falls. The bench drives start in the same half-cycle in which it acknowledges that write. It then checks that no further fetch or bus transaction follows, and that done_o stays high. A second overlap is an acknowledge in the first cycle of a request, which the bench mixes with one- and two-cycle waits on every transaction. The pulse and settle distances are measured from the accepting edge in every case, so a cycle lost or gained between the two handshakes shows up as a wrong gap.

// File: rtl/bps_pkg.sv
package bps_pkg;
   localparam int unsigned BYTE_W = 8;

   localparam logic [BYTE_W-1:0] CMD_SETUP  = 8'h40;
   localparam logic [BYTE_W-1:0] CMD_VERIFY = 8'hC0;
   localparam logic [BYTE_W-1:0] CMD_RESET  = 8'hFF;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SETUP,
      ST_LOAD,
      ST_PULSE,
      ST_VERIFY,
      ST_SETTLE,
      ST_READ,
      ST_CHECK,
      ST_FINISH
   } bps_state_e;
endpackage

// File: rtl/bps_timer.sv
module bps_timer #(
   parameter int unsigned LEN_A = 10,
   parameter int unsigned LEN_B = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic sel_b_i,
   output logic expire_o
);
   localparam int unsigned LEN_MAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
   localparam int unsigned CW      = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;

   if (LEN_A < 1) begin : g_bad_a
      $error("bps_timer: LEN_A must be at least 1");
   end
   if (LEN_B < 1) begin : g_bad_b
      $error("bps_timer: LEN_B must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= sel_b_i ? CW'(LEN_B - 1) : CW'(LEN_A - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/bps_pulse_ctr.sv
module bps_pulse_ctr #(
   parameter int unsigned MAX_PULSES = 25,
   localparam int unsigned CW = $clog2(MAX_PULSES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [CW-1:0] count_o,
   output logic          last_o
);
   if (MAX_PULSES < 1) begin : g_bad_max
      $error("bps_pulse_ctr: MAX_PULSES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;
   assign last_o  = (cnt_q == CW'(MAX_PULSES - 1));
endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
   import bps_pkg::*;
#(
   parameter int unsigned ADDR_W     = 18,
   parameter int unsigned CLK_MHZ    = 50,
   parameter int unsigned PULSE_US   = 10,
   parameter int unsigned SETTLE_US  = 6,
   parameter int unsigned MAX_PULSES = 25,
   localparam int unsigned CNT_W      = ADDR_W + 1,
   localparam int unsigned PC_W       = $clog2(MAX_PULSES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [CNT_W-1:0]  byte_count_i,
   output logic              data_req_o,
   output logic [ADDR_W-1:0] data_idx_o,
   input  logic              data_vld_i,
   input  logic [7:0]        data_i,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [7:0]        bus_wdata_o,
   input  logic              bus_ack_i,
   input  logic [7:0]        bus_rdata_i,
   output logic              vpp_en_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic [ADDR_W-1:0] fail_addr_o,
   output logic [PC_W-1:0]   fail_pulses_o
);
   localparam int unsigned PULSE_CYC  = CLK_MHZ * PULSE_US;
   localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("byte_prog_seq: ADDR_W must be at least 1");
   end
   if (PULSE_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_time
      $error("byte_prog_seq: pulse and settle times must span a cycle");
   end

   bps_state_e        st_q;
   logic [ADDR_W-1:0] base_q, addr_q, idx_q, fail_addr_q;
   logic [CNT_W-1:0]  left_q;
   logic [7:0]        exp_q, rd_q;
   logic              vpp_q, done_q, fail_q;
   logic [PC_W-1:0]   fail_pc_q;

   logic              accept, tmr_load, tmr_sel_settle, tmr_expire;
   logic              pc_clr, pc_inc, pc_last, mismatch;
   logic [PC_W-1:0]   pc_count;

   assign accept         = bus_req_o && bus_ack_i;
   assign mismatch       = (rd_q != exp_q);
   assign tmr_load       = accept && (st_q == ST_LOAD || st_q == ST_VERIFY);
   assign tmr_sel_settle = (st_q == ST_VERIFY);
   assign pc_clr         = (st_q == ST_FETCH);
   assign pc_inc         = (st_q == ST_CHECK) && mismatch;

   bps_timer #(
      .LEN_A (PULSE_CYC),
      .LEN_B (SETTLE_CYC)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .sel_b_i  (tmr_sel_settle),
      .expire_o (tmr_expire)
   );

   bps_pulse_ctr #(
      .MAX_PULSES (MAX_PULSES)
   ) i_pulse_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (pc_clr),
      .inc_i   (pc_inc),
      .count_o (pc_count),
      .last_o  (pc_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         base_q      <= '0;
         addr_q      <= '0;
         idx_q       <= '0;
         left_q      <= '0;
         exp_q       <= '0;
         rd_q        <= '0;
         vpp_q       <= 1'b0;
         done_q      <= 1'b0;
         fail_q      <= 1'b0;
         fail_addr_q <= '0;
         fail_pc_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start_i) begin
               base_q      <= base_addr_i;
               addr_q      <= base_addr_i;
               idx_q       <= '0;
               left_q      <= byte_count_i;
               vpp_q       <= 1'b1;
               done_q      <= 1'b0;
               fail_q      <= 1'b0;
               fail_addr_q <= '0;
               fail_pc_q   <= '0;
               st_q        <= (byte_count_i == '0) ? ST_FINISH : ST_FETCH;
            end
            ST_FETCH: if (data_vld_i) begin
               exp_q <= data_i;
               st_q  <= ST_SETUP;
            end
            ST_SETUP:  if (accept) st_q <= ST_LOAD;
            ST_LOAD:   if (accept) st_q <= ST_PULSE;
            ST_PULSE:  if (tmr_expire) st_q <= ST_VERIFY;
            ST_VERIFY: if (accept) st_q <= ST_SETTLE;
            ST_SETTLE: if (tmr_expire) st_q <= ST_READ;
            ST_READ: if (accept) begin
               rd_q <= bus_rdata_i;
               st_q <= ST_CHECK;
            end
            ST_CHECK: begin
               if (!mismatch) begin
                  if (left_q == CNT_W'(1)) begin
                     st_q <= ST_FINISH;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                     idx_q  <= idx_q + 1'b1;
                     left_q <= left_q - 1'b1;
                     st_q   <= ST_FETCH;
                  end
               end else if (pc_last) begin
                  vpp_q       <= 1'b0;
                  fail_q      <= 1'b1;
                  fail_addr_q <= addr_q;
                  fail_pc_q   <= pc_count + 1'b1;
                  st_q        <= ST_IDLE;
               end else begin
                  st_q <= ST_SETUP;
               end
            end
            ST_FINISH: if (accept) begin
               vpp_q  <= 1'b0;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_req_o   = 1'b0;
      bus_we_o    = 1'b1;
      bus_addr_o  = addr_q;
      bus_wdata_o = '0;
      case (st_q)
         ST_SETUP:  begin bus_req_o = 1'b1; bus_wdata_o = CMD_SETUP;  end
         ST_LOAD:   begin bus_req_o = 1'b1; bus_wdata_o = exp_q;      end
         ST_VERIFY: begin bus_req_o = 1'b1; bus_wdata_o = CMD_VERIFY; end
         ST_READ:   begin bus_req_o = 1'b1; bus_we_o    = 1'b0;       end
         ST_FINISH: begin
            bus_req_o   = 1'b1;
            bus_addr_o  = base_q;
            bus_wdata_o = CMD_RESET;
         end
         default: ;
      endcase
   end

   assign data_req_o    = (st_q == ST_FETCH);
   assign data_idx_o    = idx_q;
   assign vpp_en_o      = vpp_q;
   assign busy_o        = (st_q != ST_IDLE);
   assign done_o        = done_q;
   assign fail_o        = fail_q;
   assign fail_addr_o   = fail_addr_q;
   assign fail_pulses_o = fail_pc_q;
endmodule

// File: rtl/byte_prog_seq_chk.sv
module byte_prog_seq_chk #(
   parameter int unsigned ADDR_W     = 18,
   parameter int unsigned PC_W       = 5,
   parameter int unsigned MAX_PULSES = 25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              data_req_o,
   input logic [ADDR_W-1:0] data_idx_o,
   input logic              data_vld_i,
   input logic              bus_req_o,
   input logic              bus_we_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic [7:0]        bus_wdata_o,
   input logic              bus_ack_i,
   input logic              vpp_en_o,
   input logic              busy_o,
   input logic              done_o,
   input logic              fail_o,
   input logic [PC_W-1:0]   fail_pulses_o
);
   assert_supply_on_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o |-> vpp_en_o);

   assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o)
                                  && $stable(bus_addr_o) && $stable(bus_wdata_o));

   assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      data_req_o && !data_vld_i |=> data_req_o && $stable(data_idx_o));

   assert_fail_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> fail_pulses_o == PC_W'(MAX_PULSES) && !done_o && !vpp_en_o);

   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !vpp_en_o && !bus_req_o && !data_req_o);

   assert_status_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !start_i |=> $stable(fail_o) && $stable(done_o));
endmodule

bind byte_prog_seq byte_prog_seq_chk #(
   .ADDR_W     (ADDR_W),
   .PC_W       (PC_W),
   .MAX_PULSES (MAX_PULSES)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start_i       (start_i),
   .data_req_o    (data_req_o),
   .data_idx_o    (data_idx_o),
   .data_vld_i    (data_vld_i),
   .bus_req_o     (bus_req_o),
   .bus_we_o      (bus_we_o),
   .bus_addr_o    (bus_addr_o),
   .bus_wdata_o   (bus_wdata_o),
   .bus_ack_i     (bus_ack_i),
   .vpp_en_o      (vpp_en_o),
   .busy_o        (busy_o),
   .done_o        (done_o),
   .fail_o        (fail_o),
   .fail_pulses_o (fail_pulses_o)
);

// File: tb/test_byte_prog_seq.sv
`timescale 1ns/1ps
module test_byte_prog_seq;
   localparam int ADDR_W = 18;
   localparam int MHZ    = 1;
   localparam int P_US   = 10;
   localparam int S_US   = 6;
   localparam int MAXP   = 25;
   localparam int PCYC   = MHZ * P_US;
   localparam int SCYC   = MHZ * S_US;
   localparam int PC_W   = $clog2(MAXP + 1);
   localparam int WDOG   = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] base_addr_i = '0;
   logic [ADDR_W:0]   byte_count_i = '0;
   logic              data_req_o;
   logic [ADDR_W-1:0] data_idx_o;
   logic              data_vld_i = 1'b0;
   logic [7:0]        data_i = '0;
   logic              bus_req_o, bus_we_o;
   logic [ADDR_W-1:0] bus_addr_o;
   logic [7:0]        bus_wdata_o;
   logic              bus_ack_i = 1'b0;
   logic [7:0]        bus_rdata_i = '0;
   logic              vpp_en_o, busy_o, done_o, fail_o;
   logic [ADDR_W-1:0] fail_addr_o;
   logic [PC_W-1:0]   fail_pulses_o;

   byte_prog_seq #(
      .ADDR_W(ADDR_W), .CLK_MHZ(MHZ), .PULSE_US(P_US),
      .SETTLE_US(S_US), .MAX_PULSES(MAXP)
   ) i_byte_prog_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .base_addr_i(base_addr_i), .byte_count_i(byte_count_i),
      .data_req_o(data_req_o), .data_idx_o(data_idx_o),
      .data_vld_i(data_vld_i), .data_i(data_i),
      .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
      .vpp_en_o(vpp_en_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
      .fail_addr_o(fail_addr_o), .fail_pulses_o(fail_pulses_o)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   function automatic void chk(input bit ok, input string tag, input string what,
                               input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc == WDOG) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // reference model state
   typedef struct {bit we; int addr; int data; string tag;} txn_t;
   txn_t expq[$];
   int   tgt_m[int];
   int   need_m[int];
   int   pulses_m[int];
   int   d_arr[8];
   int   n_arr[8];
   int   prev_kind = 0;   // 0 none 1 setup 2 data 3 verify 4 read 5 reset
   int   last_prog_edge = 0;
   int   last_ver_edge = 0;
   bit   new_txn = 1'b1;
   int   wait_left = 0;
   int   wpat = 0;
   bit   arm_end = 1'b0;
   bit   end_fired = 1'b0;
   int   exp_fetch = 0;
   int   dwait = 0;

   function automatic void accept_txn();
      txn_t e;
      int   a;
      a = int'(bus_addr_o);
      if (expq.size() == 0) begin
         chk(1'b0, "R8", "unexpected bus transaction at address", a, -1);
         return;
      end
      e = expq.pop_front();
      chk(bus_we_o == e.we, e.tag, "transaction direction", bus_we_o, e.we);
      chk(a == e.addr, e.tag, "transaction address", a, e.addr);
      if (e.we) chk(int'(bus_wdata_o) == e.data, e.tag, "write data", bus_wdata_o, e.data);
      if (bus_we_o) begin
         if (prev_kind == 1) begin
            prev_kind = 2;
            if (pulses_m.exists(a)) pulses_m[a] = pulses_m[a] + 1;
            last_prog_edge = cyc + 1;
         end else if (bus_wdata_o == 8'h40) begin
            prev_kind = 1;
         end else if (bus_wdata_o == 8'hC0) begin
            prev_kind = 3;
            last_ver_edge = cyc + 1;
         end else begin
            prev_kind = 5;
            if (arm_end) begin
               arm_end = 1'b0;
               start_i = 1'b1;
               base_addr_i = 18'h00AAA;
               byte_count_i = 1;
               end_fired = 1'b1;
            end
         end
      end else begin
         prev_kind = 4;
         if (tgt_m.exists(a) && pulses_m[a] >= need_m[a]) bus_rdata_i = 8'(tgt_m[a]);
         else if (tgt_m.exists(a)) bus_rdata_i = ~8'(tgt_m[a]);
         else bus_rdata_i = 8'hFF;
      end
   endfunction

   // flash side of the bus
   always @(negedge clk) begin
      bus_ack_i = 1'b0;
      if (end_fired) begin
         start_i = 1'b0;
         end_fired = 1'b0;
      end
      if (rst_n && bus_req_o) begin
         chk(vpp_en_o === 1'b1, "R2", "supply enable during bus request", vpp_en_o, 1);
         if (new_txn) begin
            new_txn = 1'b0;
            wait_left = wpat % 3;
            wpat++;
            if (prev_kind == 2) chk(cyc - last_prog_edge == PCYC, "R3",
                                    "pulse length in cycles", cyc - last_prog_edge, PCYC);
            if (prev_kind == 3) chk(cyc - last_ver_edge == SCYC, "R4",
                                    "settle length in cycles", cyc - last_ver_edge, SCYC);
         end
         if (wait_left == 0) begin
            bus_ack_i = 1'b1;
            new_txn = 1'b1;
            accept_txn();
         end else begin
            wait_left--;
         end
      end
   end

   // data source
   always @(negedge clk) begin
      data_vld_i = 1'b0;
      if (rst_n && data_req_o) begin
         if (dwait == 0) begin
            chk(int'(data_idx_o) == exp_fetch, "R10", "fetch index", data_idx_o, exp_fetch);
            data_i = (data_idx_o < 8) ? 8'(d_arr[data_idx_o]) : 8'h00;
            data_vld_i = 1'b1;
            exp_fetch++;
            dwait = exp_fetch % 2;
         end else begin
            dwait--;
         end
      end
   end

   task automatic run(input int base, input int cnt, input bit mid, input bit endst,
                      input int fail_idx);
      bit failed;
      int a;
      int n;
      int tries;
      string tg;
      expq.delete();
      tgt_m.delete();
      need_m.delete();
      pulses_m.delete();
      exp_fetch = 0;
      prev_kind = 0;
      failed = 1'b0;
      for (int i = 0; i < cnt; i++) begin
         a = base + i;
         n = n_arr[i];
         tgt_m[a] = d_arr[i];
         need_m[a] = n;
         pulses_m[a] = 0;
         tries = (n > MAXP) ? MAXP : n;
         for (int k = 0; k < tries; k++) begin
            tg = (n > MAXP) ? "R6" : ((k == 0) ? "R2" : "R5");
            expq.push_back('{1'b1, a, 8'h40, tg});
            expq.push_back('{1'b1, a, d_arr[i], tg});
            expq.push_back('{1'b1, a, 8'hC0, "R3"});
            expq.push_back('{1'b0, a, 0, "R4"});
         end
         if (n > MAXP) begin
            failed = 1'b1;
            break;
         end
      end
      if (!failed) expq.push_back('{1'b1, base, 8'hFF, "R7"});
      arm_end = endst;
      @(negedge clk);
      start_i = 1'b1;
      base_addr_i = ADDR_W'(base);
      byte_count_i = (ADDR_W+1)'(cnt);
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o === 1'b1, "R2", "busy after start", busy_o, 1);
      chk(vpp_en_o === 1'b1, "R2", "supply enable after start", vpp_en_o, 1);
      chk(fail_o === 1'b0 && done_o === 1'b0, "R6", "status cleared by start",
          {fail_o, done_o}, 0);
      if (mid) begin
         repeat (40) @(negedge clk);
         start_i = 1'b1;
         base_addr_i = 18'h12345;
         byte_count_i = 7;
         @(negedge clk);
         start_i = 1'b0;
      end
      while (busy_o) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(busy_o === 1'b0, "R8", "idle after run", busy_o, 0);
      chk(bus_req_o === 1'b0 && data_req_o === 1'b0, "R8", "no traffic after run",
          {bus_req_o, data_req_o}, 0);
      chk(vpp_en_o === 1'b0, "R7", "supply enable dropped", vpp_en_o, 0);
      chk(expq.size() == 0, "R5", "expected transactions left", expq.size(), 0);
      chk(done_o === !failed, "R7", "done flag", done_o, !failed);
      chk(fail_o === failed, "R6", "fail flag", fail_o, failed);
      if (failed) begin
         chk(int'(fail_addr_o) == base + fail_idx, "R6", "fail address",
             fail_addr_o, base + fail_idx);
         chk(int'(fail_pulses_o) == MAXP, "R6", "fail pulse count", fail_pulses_o, MAXP);
      end else begin
         for (int i = 0; i < cnt; i++)
            chk(pulses_m[base+i] == n_arr[i], "R5", "pulses spent on byte",
                pulses_m[base+i], n_arr[i]);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(busy_o === 1'b0 && done_o === 1'b0 && fail_o === 1'b0, "R1",
          "status in reset", {busy_o, done_o, fail_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(vpp_en_o === 1'b0 && bus_req_o === 1'b0 && data_req_o === 1'b0, "R1",
          "outputs after reset", {vpp_en_o, bus_req_o, data_req_o}, 0);
      chk(busy_o === 1'b0, "R1", "busy after reset", busy_o, 0);

      // four bytes with retries, start while busy and at the final edge
      d_arr[0] = 8'hA5; n_arr[0] = 1;
      d_arr[1] = 8'hFF; n_arr[1] = 3;
      d_arr[2] = 8'h00; n_arr[2] = 1;
      d_arr[3] = 8'h3C; n_arr[3] = 2;
      run(32'h00100, 4, 1'b1, 1'b1, -1);

      // zero byte count: only the reset command
      run(32'h00200, 0, 1'b0, 1'b0, -1);

      // pulse limit: 25 pulses pass, 26 needed fails
      d_arr[0] = 8'h5A; n_arr[0] = 25;
      d_arr[1] = 8'hC3; n_arr[1] = 26;
      run(32'h3FFFE, 2, 1'b0, 1'b0, 1);

      // after a failure, the next start clears the status; data equal to a command
      d_arr[0] = 8'h40; n_arr[0] = 1;
      run(32'h00040, 1, 1'b0, 1'b0, -1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule